// File: doc/BRIEF.md
# Trapezoidal-Reference Nearest Level Modulator

This block drives one leg of a modular multilevel converter. On every sampling tick it works out how many submodules the upper arm and the lower arm should insert. The reference is not a sine. It is a symmetric trapezoid built from a sample index that counts through one fundamental period. The trapezoid is scaled by a modulation index, a small signed offset is added, and the normalized upper and lower arm values are each rounded to an integer between 0 and N. The offset pulls the two roundings apart, so their difference (the leg output level) can take 2N+1 values instead of N+1.

At low modulation index with few submodules, both arms can round to the same count for a whole period, which leaves the output at zero. The block watches for such a period. When it sees one, it switches from the next period on to a timing with four equal segments. In that mode the offset is left out of the arm values and is used instead as a rounding bias: the upper arm is biased down by |k| and the lower arm is biased up by |k|. The block goes back to normal timing at a period end once the modulation index rises above a threshold. Capacitor sorting and gate drive sit downstream and consume the two counts.

Top module: `tnlm_top`

## Requirements
- R1: While reset is held, `cnt_valid` is 0 and both counts are 0.
- R2: `cnt_valid` is high for exactly the one clock after each clock in which `tick` is high. The counts change only in that clock and hold their values otherwise.
- R3: A modulation index above 32768 (1.0 in unsigned Q1.15) behaves exactly like 32768.
- R4: The sample index s runs from 0 to P-1, with P the captured period length. In normal mode the segment lengths are R = floor(P/3) and H = floor(P/6). The reference is:
  - -1 + floor(65536·s/R)/32768 for s < R;
  - +1 for R ≤ s < R+H;
  - +1 - floor(65536·(s-R-H)/R)/32768 for R+H ≤ s < 2R+H;
  - -1 for the remaining samples.
- R5: In normal mode, with the offset k in signed Q2.14, the upper count is floor((N/2)(1 - MI·tra) + k + 1/2) and the lower count is floor((N/2)(1 + MI·tra) + k + 1/2), computed exactly. A fraction of exactly one half therefore rounds up.
- R6: Both counts saturate to the range 0..N, including for offsets near ±2.0.
- R7: `per_len` is sampled only on the tick with sample index 0. A change in the middle of a period has no effect until the next period starts.
- R8: Suppose every tick of a complete period gives equal upper and lower counts. Then, starting with the next period, the block runs in fine mode with R = H = floor(P/4).
- R9: In fine mode the offset is dropped. The upper count is floor((N/2)(1 - MI·tra) + 1/2 - |k|) and the lower count is floor((N/2)(1 + MI·tra) + 1/2 + |k|), both saturated to 0..N.
- R10: At the end of a period that was not all-zero, fine mode continues only if the clamped modulation index on that last tick is at most LOW_MI (6554 by default). Otherwise the next period is normal. A mode change never happens anywhere except at a period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sampling strobe, one clock wide |
| mod_idx | input | 16 | Modulation index, unsigned Q1.15, values above 1.0 are clamped |
| offset | input | 16 | Signed offset k, Q2.14 |
| per_len | input | PER_W | Samples per fundamental period, at least 8 |
| up_cnt | output | $clog2(N_SUB+1) | Inserted submodules, upper arm |
| lo_cnt | output | $clog2(N_SUB+1) | Inserted submodules, lower arm |
| cnt_valid | output | 1 | Counts updated in this clock |

## Verification
A sample index that is out of step with the period shows up as wrong counts on the ramp ticks within that period. The bench sees it on the first tick where the trapezoid value differs, so at most one period late. A mode register that latched wrongly stays hidden while the two formulas happen to agree. It appears on the first ramp or extreme sample of the following period, because the timing and the biases there differ from those of the other mode. A zero flag that clears too late or too early moves the mode switch by one whole period, and the directed zero-collapse sequence exposes that within two periods.

// File: rtl/tnlm_pkg.sv
// Shared types and fixed-point constants for the trapezoidal nearest level
// modulator. The reference full scale is 32768 (1.0 in Q1.15). Arm sums are
// kept in a Q.31 scale inside a wide signed accumulator.
package tnlm_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_FINE   = 1'b1
    } tnlm_mode_e;

    localparam int TRA_W = 17;
    localparam int ACC_W = 48;
    localparam logic signed [TRA_W-1:0] TRA_FS = 17'sd32768;
    localparam logic [15:0] MI_ONE = 16'd32768;
endpackage

// File: rtl/tnlm_phase.sv
// Sample index counter for one fundamental period. It captures the period
// length on the tick at index 0 and derives the segment lengths for the
// active mode. Assumes per_len >= 8 so that every segment is non-empty.
module tnlm_phase
    import tnlm_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] per_len,
    input  tnlm_mode_e       mode,
    output logic [PER_W-1:0] idx,
    output logic [PER_W-1:0] rise_len,
    output logic [PER_W-1:0] high_len,
    output logic             first,
    output logic             last
);
    localparam logic [PER_W-1:0] DIV3 = PER_W'(3);
    localparam logic [PER_W-1:0] DIV6 = PER_W'(6);

    logic [PER_W-1:0] idx_q;
    logic [PER_W-1:0] len_q;
    logic [PER_W-1:0] eff_len;

    // The period length in force: the live input at index 0, the captured one after.
    assign eff_len = (idx_q == '0) ? per_len : len_q;
    assign first   = (idx_q == '0);
    assign last    = (idx_q == eff_len - 1'b1);
    assign idx     = idx_q;

    // Segment lengths for the active mode.
    always_comb begin
        if (mode == MODE_FINE) begin
            rise_len = eff_len >> 2;
            high_len = eff_len >> 2;
        end else begin
            rise_len = eff_len / DIV3;
            high_len = eff_len / DIV6;
        end
    end

    // Step the index on each tick and capture the length at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (tick) begin
            if (idx_q == '0) begin
                len_q <= per_len;
            end
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

    // R7
    idx_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != '0) |-> (idx_q < len_q));
endmodule

// File: rtl/tnlm_trap.sv
// Combinational trapezoid value for one sample index. The period begins with
// a rising ramp from -1 to +1, then a high hold, a falling ramp and a low
// hold. The output is signed with a full scale of 32768.
module tnlm_trap
    import tnlm_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic [PER_W-1:0]        idx,
    input  logic [PER_W-1:0]        rise_len,
    input  logic [PER_W-1:0]        high_len,
    output logic signed [TRA_W-1:0] tra
);
    localparam int NW = PER_W + 17;

    logic [PER_W-1:0]        top_start;
    logic [PER_W-1:0]        fall_start;
    logic [PER_W-1:0]        low_start;
    logic [PER_W-1:0]        step;
    logic [NW-1:0]           quo;
    logic signed [TRA_W-1:0] ramp;

    assign top_start  = rise_len;
    assign fall_start = rise_len + high_len;
    assign low_start  = fall_start + rise_len;

    // Position inside the current ramp and its scaled fraction of the swing.
    always_comb begin
        step = (idx < top_start) ? idx : idx - fall_start;
        quo  = (NW'(step) << 16) / NW'(rise_len);
        ramp = signed'(TRA_W'(quo));
    end

    // Select the segment shape.
    always_comb begin
        if (idx < top_start) begin
            tra = ramp - TRA_FS;
        end else if (idx < fall_start) begin
            tra = TRA_FS;
        end else if (idx < low_start) begin
            tra = TRA_FS - ramp;
        end else begin
            tra = -TRA_FS;
        end
    end
endmodule

// File: rtl/tnlm_arm_round.sv
// Arm level for one arm: scales the reference by the modulation index, adds
// the offset (normal mode) or an offset-sized rounding bias (fine mode), and
// rounds half up, saturating to 0..N_SUB. LOWER selects the sign of the
// reference term. Assumes mi is already clamped to 1.0.
module tnlm_arm_round
    import tnlm_pkg::*;
#(
    parameter int N_SUB = 4,
    parameter int CW    = 3,
    parameter bit LOWER = 1'b0
) (
    input  logic [15:0]             mi,
    input  logic signed [TRA_W-1:0] tra,
    input  logic signed [15:0]      offset,
    input  tnlm_mode_e              mode,
    output logic [CW-1:0]           cnt
);
    localparam logic signed [ACC_W-1:0] ONE30 = ACC_W'(64'sd1 <<< 30);
    localparam logic signed [ACC_W-1:0] HALF  = ONE30;
    localparam logic signed [ACC_W-1:0] NS    = ACC_W'(N_SUB);

    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] span;
    logic signed [ACC_W-1:0] koff;
    logic signed [ACC_W-1:0] kabs;
    logic signed [ACC_W-1:0] bias;
    logic signed [ACC_W-1:0] level;

    // Normalized arm value in Q.31 (N times 1 +/- MI*tra at Q.30).
    always_comb begin
        prod = ACC_W'($signed({1'b0, mi})) * ACC_W'(tra);
        span = LOWER ? (ONE30 + prod) : (ONE30 - prod);
        koff = ACC_W'(offset) <<< 17;
        kabs = (koff < 0) ? -koff : koff;
    end

    // Rounding bias for the active mode.
    always_comb begin
        if (mode == MODE_FINE) begin
            bias = LOWER ? (HALF + kabs) : (HALF - kabs);
        end else begin
            bias = HALF + koff;
        end
    end

    // Floor of the biased value, then saturation.
    always_comb begin
        level = (span * NS + bias) >>> 31;
        if (level < 0) begin
            cnt = '0;
        end else if (level > NS) begin
            cnt = CW'(N_SUB);
        end else begin
            cnt = CW'(level);
        end
    end
endmodule

// File: rtl/tnlm_zero_mon.sv
// Tracks whether every tick of the current period gave equal arm counts and
// chooses the mode of the next period at the period end. Assumes first and
// last come from the sample counter of the same leg.
module tnlm_zero_mon
    import tnlm_pkg::*;
#(
    parameter logic [15:0] LOW_MI = 16'd6554
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        first,
    input  logic        last,
    input  logic        same,
    input  logic [15:0] mi,
    output tnlm_mode_e  mode
);
    logic       zero_q;
    logic       zero_now;
    tnlm_mode_e mode_q;

    // Running all-zero flag, restarted at index 0.
    assign zero_now = first ? same : (zero_q & same);
    assign mode     = mode_q;

    // Update the flag per tick and the mode at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
            mode_q <= MODE_NORMAL;
        end else if (tick) begin
            zero_q <= zero_now;
            if (last) begin
                if (zero_now) begin
                    mode_q <= MODE_FINE;
                end else if (mode_q == MODE_FINE && mi <= LOW_MI) begin
                    mode_q <= MODE_FINE;
                end else begin
                    mode_q <= MODE_NORMAL;
                end
            end
        end
    end

    // R10
    mode_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(tick && last));

    // R8
    zero_goes_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && last && zero_now) |=> (mode_q == MODE_FINE));
endmodule

// File: rtl/tnlm_top.sv
// Trapezoidal-reference nearest level modulator for one converter leg.
// Per sampling tick it registers the inserted-submodule counts of both arms
// and pulses cnt_valid for one clock. Assumes per_len >= 8 and one-clock ticks.
module tnlm_top
    import tnlm_pkg::*;
#(
    parameter int N_SUB  = 4,
    parameter int PER_W  = 12,
    parameter int LOW_MI = 6554
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [15:0]                mod_idx,
    input  logic signed [15:0]         offset,
    input  logic [PER_W-1:0]           per_len,
    output logic [$clog2(N_SUB+1)-1:0] up_cnt,
    output logic [$clog2(N_SUB+1)-1:0] lo_cnt,
    output logic                       cnt_valid
);
    localparam int CW = $clog2(N_SUB + 1);
    localparam logic [15:0] LOW_MI_Q = 16'(LOW_MI);

    logic [15:0]             mi_c;
    tnlm_mode_e              mode;
    logic [PER_W-1:0]        idx;
    logic [PER_W-1:0]        rise_len;
    logic [PER_W-1:0]        high_len;
    logic                    first;
    logic                    last;
    logic signed [TRA_W-1:0] tra;
    logic [CW-1:0]           arm_cnt [2];
    logic [CW-1:0]           up_q;
    logic [CW-1:0]           lo_q;
    logic                    valid_q;

    // Clamp the modulation index to 1.0.
    assign mi_c = (mod_idx > MI_ONE) ? MI_ONE : mod_idx;

    tnlm_phase #(.PER_W(PER_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .per_len  (per_len),
        .mode     (mode),
        .idx      (idx),
        .rise_len (rise_len),
        .high_len (high_len),
        .first    (first),
        .last     (last)
    );

    tnlm_trap #(.PER_W(PER_W)) u_trap (
        .idx      (idx),
        .rise_len (rise_len),
        .high_len (high_len),
        .tra      (tra)
    );

    // One rounder per arm: index 0 upper, index 1 lower.
    for (genvar a = 0; a < 2; a++) begin : g_arm
        tnlm_arm_round #(
            .N_SUB (N_SUB),
            .CW    (CW),
            .LOWER (a == 1)
        ) u_arm (
            .mi     (mi_c),
            .tra    (tra),
            .offset (offset),
            .mode   (mode),
            .cnt    (arm_cnt[a])
        );
    end

    tnlm_zero_mon #(.LOW_MI(LOW_MI_Q)) u_zero (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .first (first),
        .last  (last),
        .same  (arm_cnt[0] == arm_cnt[1]),
        .mi    (mi_c),
        .mode  (mode)
    );

    // Register the counts on a tick and raise the strobe for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= '0;
            lo_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick;
            if (tick) begin
                up_q <= arm_cnt[0];
                lo_q <= arm_cnt[1];
            end
        end
    end

    assign up_cnt    = up_q;
    assign lo_cnt    = lo_q;
    assign cnt_valid = valid_q;

    // R2
    valid_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(tick));

    // R2
    counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> ($stable(up_q) && $stable(lo_q)));

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q <= CW'(N_SUB)) && (lo_q <= CW'(N_SUB)));

    // R4
    tra_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tra >= -TRA_FS) && (tra <= TRA_FS));
endmodule

// File: tb/sim_tnlm_top.sv
`timescale 1ns/1ps
module sim_tnlm_top;
    localparam int N      = 4;
    localparam int PW     = 12;
    localparam int LOWMI  = 6554;
    localparam int CW     = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [15:0]       mod_idx = '0;
    logic signed [15:0] offset = '0;
    logic [PW-1:0]     per_len = PW'(30);
    logic [CW-1:0]     up_cnt;
    logic [CW-1:0]     lo_cnt;
    logic              cnt_valid;

    int n_chk = 0;
    int n_bad = 0;

    // Golden model state
    int  m_idx = 0;
    int  m_len = 0;
    bit  m_fine = 1'b0;
    bit  m_zero = 1'b0;
    int  last_up = 0;
    int  last_lo = 0;

    always #2 clk = ~clk;

    tnlm_top #(.N_SUB(N), .PER_W(PW), .LOW_MI(LOWMI)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mod_idx   (mod_idx),
        .offset    (offset),
        .per_len   (per_len),
        .up_cnt    (up_cnt),
        .lo_cnt    (lo_cnt),
        .cnt_valid (cnt_valid)
    );

    task automatic check_eq(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Trapezoid value per R4 (normal) and R8 (fine timing).
    function automatic int ref_tra(input int s, input int p, input bit fine);
        int r, h;
        r = fine ? p / 4 : p / 3;
        h = fine ? p / 4 : p / 6;
        if (s < r)            return -32768 + (65536 * s) / r;
        else if (s < r + h)   return 32768;
        else if (s < 2*r + h) return 32768 - (65536 * (s - r - h)) / r;
        else                  return -32768;
    endfunction

    function automatic int sat(input longint v);
        if (v < 0) return 0;
        if (v > N) return N;
        return int'(v);
    endfunction

    // Arm counts per R3, R5, R6 and R9.
    task automatic ref_arms(input int s, input int p, input bit fine, input int mi,
                            input int k, output int up, output int lo);
        longint mic, prod, one, kq, ka, vu, vl, bu, bl;
        mic  = (mi > 32768) ? 32768 : mi;
        prod = mic * longint'(ref_tra(s, p, fine));
        one  = longint'(1) <<< 30;
        kq   = longint'(k) * 131072;
        ka   = (kq < 0) ? -kq : kq;
        vu   = N * (one - prod);
        vl   = N * (one + prod);
        if (fine) begin
            bu = one - ka;
            bl = one + ka;
        end else begin
            bu = one + kq;
            bl = one + kq;
        end
        up = sat((vu + bu) >>> 31);
        lo = sat((vl + bl) >>> 31);
    endtask

    // Advance the model by one tick, per R7, R8 and R10.
    task automatic model_step(input int mi, input int k, input int len, output int up, output int lo);
        int  eff;
        bit  z;
        int  mic;
        mic = (mi > 32768) ? 32768 : mi;
        if (m_idx == 0) begin
            eff   = len;
            m_len = len;
        end else begin
            eff = m_len;
        end
        ref_arms(m_idx, eff, m_fine, mi, k, up, lo);
        z = (m_idx == 0) ? (up == lo) : (m_zero && (up == lo));
        m_zero = z;
        if (m_idx == eff - 1) begin
            if (z)                               m_fine = 1'b1;
            else if (m_fine && mic <= LOWMI)     m_fine = 1'b1;
            else                                 m_fine = 1'b0;
            m_idx = 0;
        end else begin
            m_idx = m_idx + 1;
        end
    endtask

    // One sampling tick with check of strobe and counts.
    task automatic do_tick(input int mi, input int k, input int len, input string tag);
        int eu, el;
        @(negedge clk);
        check_eq("R2", "idle valid", int'(cnt_valid), 0);
        check_eq("R2", "held up", int'(up_cnt), last_up);
        check_eq("R2", "held lo", int'(lo_cnt), last_lo);
        mod_idx = mi[15:0];
        offset  = k[15:0];
        per_len = len[PW-1:0];
        tick    = 1'b1;
        model_step(mi, k, len, eu, el);
        @(negedge clk);
        tick = 1'b0;
        check_eq("R2", "valid", int'(cnt_valid), 1);
        check_eq(tag, "up_cnt", int'(up_cnt), eu);
        check_eq(tag, "lo_cnt", int'(lo_cnt), el);
        last_up = eu;
        last_lo = el;
    endtask

    initial begin : watchdog
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "valid in reset", int'(cnt_valid), 0);
        check_eq("R1", "up in reset", int'(up_cnt), 0);
        check_eq("R1", "lo in reset", int'(lo_cnt), 0);
        rst_n = 1'b1;

        // R5 and R4: full index, offset -0.11, two periods
        for (int i = 0; i < 60; i++) do_tick(32768, -1802, 30, "R5");
        // R3: index above full scale behaves as 1.0
        for (int i = 0; i < 30; i++) do_tick(65535, 1802, 30, "R3");
        // R6: offset near +2 and near -2 saturate
        for (int i = 0; i < 30; i++) do_tick(32768, 32767, 30, "R6");
        for (int i = 0; i < 30; i++) do_tick(32768, -32768, 30, "R6");
        // R7: length change in mid period is ignored until the next start
        for (int i = 0; i < 5; i++)  do_tick(30000, -1000, 24, "R7");
        for (int i = 5; i < 24; i++) do_tick(30000, -1000, 40, "R7");
        for (int i = 0; i < 40; i++) do_tick(30000, -1000, 40, "R7");
        // R8: zero output for a whole period, then fine timing
        for (int i = 0; i < 40; i++) do_tick(3277, 0, 20, "R8");
        for (int i = 0; i < 20; i++) do_tick(5898, -3277, 20, "R8");
        // R9: fine rounding continues at low index
        for (int i = 0; i < 40; i++) do_tick(5898, -3277, 20, "R9");
        // R10: raised index returns to normal after the period end
        for (int i = 0; i < 60; i++) do_tick(16384, -3277, 20, "R10");
        // Random mix with captured lengths
        for (int i = 0; i < 400; i++) begin
            int mi, k, len;
            mi  = int'($urandom_range(40000, 0));
            k   = int'($urandom_range(6554, 0)) - 3277;
            len = int'($urandom_range(40, 12));
            do_tick(mi, k, len, "R4");
        end
        @(negedge clk);
        check_eq("R2", "final idle", int'(cnt_valid), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule